// File: doc/BRIEF.md
# Parallel Configuration Register Port

This block sits behind a 10-bit bidirectional pad bus that a converter shares between two jobs: returning conversion samples to a host and accepting configuration words from it. When the active-low output enable is low, the block drives the sample code and the out-of-range flag onto the pads. When it is high, both drivers float, and the host may present a word on the bus and pulse a write strobe. The two top bus bits pick a destination register and the lower eight bits carry the data.

The strobe is asynchronous to the block clock. It passes through a two-stage synchroniser, and a small state machine turns each completed strobe into a single write pulse. The machine has three states. IDLE waits for the strobe. ARMED tracks a strobe seen with the drivers off. BLOCKED swallows a strobe that overlapped a period of enabled drivers. The transitions are:
- IDLE→ARMED: the strobe is high and the enable is high.
- IDLE→BLOCKED: the strobe is high and the enable is low.
- ARMED→IDLE: the strobe falls. This transition commits the write.
- ARMED→BLOCKED: the enable drops while the strobe is still high.
- ARMED→IDLE without a commit: the enable drops and the strobe falls in the same cycle.
- BLOCKED→IDLE: the strobe falls.

The held settings are a 10-bit clamp DAC code, split over two registers, and a control register. The control register holds the gain select, power-down, clamp source, output format and clamp amplifier disable. Every field is exported to the rest of the chip as a plain signal.

Top module: `cfg_bus_port`

## Requirements
- R1: A write with bus bits [9:8] = 00 loads bus bits [7:0] into clamp code bits [7:0] and leaves clamp code bits [9:8] unchanged.
- R2: A write with bus bits [9:8] = 01 loads bus bits [1:0] into clamp code bits [9:8]. Bus bits [7:2] have no effect.
- R3: A write with bus bits [9:8] = 10 loads the control fields from these bus bits: [2:0] gain select, 3 power-down, 4 clamp source internal, 5 two's complement format, 6 clamp amplifier off. Bus bit 7 has no effect.
- R4: A write with bus bits [9:8] = 11 changes no exported field.
- R5: While reset is asserted, the clamp code is 0, the gain select is 3'b001, and power-down, clamp source, format and amplifier-off are all 0.
- R6: A write takes effect on the falling edge of the strobe. No exported field changes while the strobe is held high. The new value is visible no later than the third rising clock edge after the strobe falls. Each strobe produces at most one single-cycle write.
- R7: While the output enable is low, the pads are driven (dq_oe = 1, ovr_oe = 1) with the sample code and the out-of-range flag. While it is high, both drive enables are 0.
- R8: A strobe during which the output enable is low at any point while the synchronised strobe is high changes no exported field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low pad output enable |
| wr_stb | input | 1 | Asynchronous write strobe, commits on its falling edge |
| dq_i | input | 10 | Bus value seen at the pads |
| dq_o | output | 10 | Sample code driven to the pads |
| dq_oe | output | 1 | Data pad drive enable |
| sample_code | input | 10 | Conversion result from the converter |
| sample_ovr | input | 1 | Out-of-range flag from the converter |
| ovr_o | output | 1 | Out-of-range value for its pad |
| ovr_oe | output | 1 | Out-of-range pad drive enable |
| clamp_code | output | 10 | Clamp DAC code |
| gain_sel | output | 3 | Gain select code |
| pwr_down | output | 1 | Power-down request |
| clamp_src_int | output | 1 | Clamp level taken from the internal DAC |
| fmt_twos | output | 1 | Two's complement sample format |
| clamp_amp_off | output | 1 | Clamp amplifier disable |

## Verification
A vector table writes all four destination codes in turn. It uses words whose unused bits are set, so that a decoder that ignores the select bits, or that leaks bit 7 or bits [7:2] into a field, gives a visible difference. Two writes to the upper clamp register with different low bits, and a low-byte write of zero after a high-part write, tell apart a shared register from two independent halves. Directed strobes show the difference between commit-on-fall and commit-on-rise: one holds the strobe high for a long time, one is issued with the drivers enabled, and one has the enable dropping mid-strobe. A second reset confirms the default gain code.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int BUS_W  = 10;
    localparam int SEL_W  = 2;
    localparam int LO_W   = 8;
    localparam int HI_W   = BUS_W - LO_W;
    localparam int GAIN_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_BLOCKED = 2'd2
    } wr_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CLAMP_LO = 2'b00,
        SEL_CLAMP_HI = 2'b01,
        SEL_CTRL     = 2'b10,
        SEL_RSVD     = 2'b11
    } sel_e;

    typedef struct packed {
        logic              clamp_amp_off;
        logic              fmt_twos;
        logic              clamp_src_int;
        logic              pwr_down;
        logic [GAIN_W-1:0] gain;
    } ctrl_t;

    localparam int    CTRL_W     = $bits(ctrl_t);
    localparam ctrl_t CTRL_RESET = '{clamp_amp_off: 1'b0, fmt_twos: 1'b0,
                                     clamp_src_int: 1'b0, pwr_down: 1'b0,
                                     gain: 3'b001};

endpackage

// File: rtl/cfg_stb_sync.sv
module cfg_stb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_wr_fsm.sv
module cfg_wr_fsm
    import cfg_port_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_hi,
    input  logic         oe_n,
    input  logic [W-1:0] dq_i,
    output logic         wr_pulse,
    output logic [W-1:0] wr_word
);

    wr_state_e    state_q, state_d;
    logic [W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stb_hi) state_d = oe_n ? ST_ARMED : ST_BLOCKED;
            end
            ST_ARMED: begin
                if (!oe_n)       state_d = stb_hi ? ST_BLOCKED : ST_IDLE;
                else if (!stb_hi) state_d = ST_IDLE;
            end
            ST_BLOCKED: begin
                if (!stb_hi) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_pulse = (state_q == ST_ARMED) && !stb_hi && oe_n;
    end

    // Bus value captured while the strobe is high and drivers are off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                snap_q <= '0;
        else if (stb_hi && oe_n)   snap_q <= dq_i;
    end

    assign wr_word = snap_q;

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_port_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_pulse,
    input  logic [W-1:0] wr_word,
    output logic [W-1:0] clamp_code,
    output ctrl_t        ctrl
);

    localparam int HW = W - LO_W;

    sel_e            sel;
    logic [LO_W-1:0] lo_q;
    logic [HW-1:0]   hi_q;
    ctrl_t           ctrl_q;
    logic            unused_bits;

    assign sel         = sel_e'(wr_word[W-1 -: SEL_W]);
    assign unused_bits = ^wr_word[LO_W-1:CTRL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 lo_q <= '0;
        else if (wr_pulse && sel == SEL_CLAMP_LO)   lo_q <= wr_word[LO_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 hi_q <= '0;
        else if (wr_pulse && sel == SEL_CLAMP_HI)   hi_q <= wr_word[HW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 ctrl_q <= CTRL_RESET;
        else if (wr_pulse && sel == SEL_CTRL)       ctrl_q <= ctrl_t'(wr_word[CTRL_W-1:0]);
    end

    assign clamp_code = {hi_q, lo_q};
    assign ctrl       = ctrl_q;

endmodule

// File: rtl/cfg_bus_port.sv
module cfg_bus_port
    import cfg_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              wr_stb,
    input  logic [BUS_W-1:0]  dq_i,
    output logic [BUS_W-1:0]  dq_o,
    output logic              dq_oe,
    input  logic [BUS_W-1:0]  sample_code,
    input  logic              sample_ovr,
    output logic              ovr_o,
    output logic              ovr_oe,
    output logic [BUS_W-1:0]  clamp_code,
    output logic [GAIN_W-1:0] gain_sel,
    output logic              pwr_down,
    output logic              clamp_src_int,
    output logic              fmt_twos,
    output logic              clamp_amp_off
);

    logic             stb_hi;
    logic             wr_pulse;
    logic [BUS_W-1:0] wr_word;
    ctrl_t            ctrl_s;

    cfg_stb_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wr_stb),
        .sync_o  (stb_hi)
    );

    cfg_wr_fsm #(.W(BUS_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_hi   (stb_hi),
        .oe_n     (oe_n),
        .dq_i     (dq_i),
        .wr_pulse (wr_pulse),
        .wr_word  (wr_word)
    );

    cfg_regs #(.W(BUS_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_pulse   (wr_pulse),
        .wr_word    (wr_word),
        .clamp_code (clamp_code),
        .ctrl       (ctrl_s)
    );

    assign dq_o          = sample_code;
    assign ovr_o         = sample_ovr;
    assign dq_oe         = !oe_n;
    assign ovr_oe        = !oe_n;
    assign gain_sel      = ctrl_s.gain;
    assign pwr_down      = ctrl_s.pwr_down;
    assign clamp_src_int = ctrl_s.clamp_src_int;
    assign fmt_twos      = ctrl_s.fmt_twos;
    assign clamp_amp_off = ctrl_s.clamp_amp_off;

endmodule

// File: rtl/cfg_bus_port_chk.sv
module cfg_bus_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       oe_n,
    input logic       dq_oe,
    input logic       ovr_oe,
    input logic       wr_pulse,
    input logic [9:0] wr_word,
    input logic [9:0] clamp_code,
    input logic [6:0] ctrl_bits
);

    assert_reset_R5: assert property (@(posedge clk)
        !rst_n |=> (clamp_code == 10'h000 && ctrl_bits == 7'h01));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> ($stable(clamp_code) && $stable(ctrl_bits)));

    assert_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    assert_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_word[9:8] == 2'b00) |=>
        (clamp_code[7:0] == $past(wr_word[7:0]) && clamp_code[9:8] == $past(clamp_code[9:8])));

    assert_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_word[9:8] == 2'b01) |=>
        (clamp_code[9:8] == $past(wr_word[1:0]) && clamp_code[7:0] == $past(clamp_code[7:0])));

    assert_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_word[9:8] == 2'b10) |=> (ctrl_bits == $past(wr_word[6:0])));

    assert_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_word[9:8] == 2'b11) |=> ($stable(clamp_code) && $stable(ctrl_bits)));

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> oe_n);

    assert_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dq_oe && !ovr_oe));

    assert_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (dq_oe && ovr_oe));

endmodule

bind cfg_bus_port cfg_bus_port_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_n       (oe_n),
    .dq_oe      (dq_oe),
    .ovr_oe     (ovr_oe),
    .wr_pulse   (wr_pulse),
    .wr_word    (wr_word),
    .clamp_code (clamp_code),
    .ctrl_bits  (ctrl_s)
);

// File: tb/cfg_bus_port_tb_top.sv
module cfg_bus_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe_n = 1'b1;
    logic       wr_stb = 1'b0;
    logic [9:0] dq_i = '0;
    logic [9:0] dq_o;
    logic       dq_oe;
    logic [9:0] sample_code = '0;
    logic       sample_ovr = 1'b0;
    logic       ovr_o, ovr_oe;
    logic [9:0] clamp_code;
    logic [2:0] gain_sel;
    logic       pwr_down, clamp_src_int, fmt_twos, clamp_amp_off;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_bus_port dut_i (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .wr_stb(wr_stb), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe), .sample_code(sample_code), .sample_ovr(sample_ovr),
        .ovr_o(ovr_o), .ovr_oe(ovr_oe), .clamp_code(clamp_code), .gain_sel(gain_sel),
        .pwr_down(pwr_down), .clamp_src_int(clamp_src_int), .fmt_twos(fmt_twos),
        .clamp_amp_off(clamp_amp_off)
    );

    // {bus word, expected clamp code, expected control bits}
    localparam logic [26:0] VEC [0:6] = '{
        {10'h099, 10'h099, 7'h01},  // R1 low byte
        {10'h101, 10'h199, 7'h01},  // R2 upper bits
        {10'h1FE, 10'h299, 7'h01},  // R2 bits [7:2] ignored
        {10'h235, 10'h299, 7'h35},  // R3 control fields
        {10'h2CA, 10'h299, 7'h4A},  // R3 bit 7 ignored
        {10'h3FF, 10'h299, 7'h4A},  // R4 reserved
        {10'h000, 10'h200, 7'h4A}   // R1 zero low byte
    };

    function automatic string tag_of(int i);
        case (i)
            0, 6:    return "R1";
            1, 2:    return "R2";
            3, 4:    return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [6:0] ctrl_now();
        return {clamp_amp_off, fmt_twos, clamp_src_int, pwr_down, gain_sel};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_word(logic [9:0] w);
        @(negedge clk);
        oe_n = 1'b1; dq_i = w; wr_stb = 1'b1;
        repeat (4) @(negedge clk);
        wr_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R5 reset clamp", clamp_code, 10'h000);
        chk("R5 reset ctrl", ctrl_now(), 7'h01);
        rst_n = 1'b1;

        for (int i = 0; i < 7; i++) begin
            write_word(VEC[i][26:17]);
            chk({tag_of(i), " clamp"}, clamp_code, VEC[i][16:7]);
            chk({tag_of(i), " ctrl"}, ctrl_now(), VEC[i][6:0]);
        end

        // R6: nothing changes while the strobe is held high; visible within 3 edges after fall
        @(negedge clk);
        oe_n = 1'b1; dq_i = 10'h055; wr_stb = 1'b1;
        repeat (8) @(negedge clk);
        chk("R6 held high", clamp_code, 10'h200);
        wr_stb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 after fall", clamp_code, 10'h255);

        // R8: strobe entirely within enabled drivers
        @(negedge clk);
        oe_n = 1'b0; dq_i = 10'h0AA; wr_stb = 1'b1;
        repeat (5) @(negedge clk);
        wr_stb = 1'b0;
        repeat (5) @(negedge clk);
        oe_n = 1'b1;
        @(negedge clk);
        chk("R8 strobe while enabled", clamp_code, 10'h255);

        // R8: enable dips low in the middle of a strobe
        dq_i = 10'h011; wr_stb = 1'b1;
        repeat (4) @(negedge clk);
        oe_n = 1'b0;
        repeat (2) @(negedge clk);
        oe_n = 1'b1;
        repeat (2) @(negedge clk);
        wr_stb = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 enable dip", clamp_code, 10'h255);

        // R7: pad drive
        oe_n = 1'b0; sample_code = 10'h2A5; sample_ovr = 1'b1;
        #1;
        chk("R7 dq_oe on", dq_oe, 1);
        chk("R7 dq_o", dq_o, 10'h2A5);
        chk("R7 ovr_oe on", ovr_oe, 1);
        chk("R7 ovr_o", ovr_o, 1);
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        chk("R7 dq_oe off", dq_oe, 0);
        chk("R7 ovr_oe off", ovr_oe, 0);

        // R5: second reset restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 re-reset clamp", clamp_code, 10'h000);
        chk("R5 re-reset gain", gain_sel, 3'b001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule